// File: doc/BRIEF.md
# Exception Return State Unit

This unit keeps a processor's interrupt-related status and its resume addresses for up to two nested exception levels, and it performs the state pop that a return-from-exception instruction needs. One status word holds the live flags (stack mode, interrupt enable, condition) together with a first-level saved copy of the same three flags. A separate outer status register holds a second-level saved copy. Two address registers hold the first-level and second-level resume addresses.

Software reaches every register through a small indexed control-register port. It has a write enable, a 4-bit index and a 32-bit data bus, and the read bus is combinational. When the pipeline raises the one-cycle return strobe, the unit does three things in the same cycle. It drives the redirect address, which is the first-level resume address with its two lowest bits cleared. It shifts the saved flags down one level. It moves the second-level resume address into the first level. Pushing state on exception entry is done elsewhere.

Top module: `exr_unit`

## Requirements
- R1: After reset, every register reads as zero at every index.
- R2: Index 0 is the status word. Live stack-mode, interrupt-enable and condition flags sit at bits 7, 6 and 0. Their first-level saved copies sit at bits 15, 14 and 8. All other bits read as zero and ignore writes.
- R3: Index 1 is the outer status register. It holds the second-level saved stack-mode, interrupt-enable and condition flags at bits 7, 6 and 0. All other bits read as zero.
- R4: Index 2 is the first-level resume address and index 3 is the second-level resume address, both 32 bits wide. Indices 4 to 15 read as zero, and writing them changes no register.
- R5: On a return strobe, the live flags (bits 7, 6, 0) take the values that bits 15, 14, 8 held before the strobe.
- R6: On a return strobe, status bits 15, 14, 8 take the outer status register's bits 7, 6, 0. The outer status register keeps its value.
- R7: While the return strobe is high, redirect_valid is high and redirect_pc equals the first-level resume address with bits 1:0 forced to zero. Otherwise redirect_valid is low.
- R8: On a return strobe, the first-level resume address takes the second-level resume address. The second-level resume address keeps its value.
- R9: If a register write and a return strobe occur in the same cycle, the return takes effect and the write is dropped.
- R10: A write becomes visible on the read bus right after the clock edge that accepts it. The read bus follows the index with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| creg_we | input | 1 | Control-register write enable |
| creg_idx | input | 4 | Control-register index |
| creg_wdata | input | 32 | Control-register write data |
| creg_rdata | output | 32 | Control-register read data, combinational |
| ret_strobe | input | 1 | One-cycle return-from-exception request |
| redirect_valid | output | 1 | High while the return strobe is high |
| redirect_pc | output | 32 | Program counter to resume at |

## Verification
The redirect outputs are combinational, so the bench checks them in the same cycle the strobe is driven. It raises the strobe on a falling edge and samples a moment later, before the next rising edge. The register results of a write or a return land on the next rising edge. The bench reads them back at the falling edge after that edge, which is one register stage from the stimulus. The sweep covers all 64 live/first-level flag combinations against all 8 outer-flag combinations. Each case is read back before and after the pop, and directed cases cover reset, the unused indices and the write-versus-return collision.

// File: rtl/exr_pkg.sv
package exr_pkg;

   localparam int unsigned SM_POS   = 7;
   localparam int unsigned IE_POS   = 6;
   localparam int unsigned CD_POS   = 0;
   localparam int unsigned LVL_SHIFT = 8;

   localparam int unsigned IDX_STATUS = 0;
   localparam int unsigned IDX_OUTER  = 1;
   localparam int unsigned IDX_RA1    = 2;
   localparam int unsigned IDX_RA2    = 3;

   typedef struct packed {
      logic sm;
      logic ie;
      logic cd;
   } flags_t;

   function automatic flags_t pick_flags(input logic [15:0] w, input bit upper);
      flags_t f;
      if (upper) begin
         f.sm = w[LVL_SHIFT + SM_POS];
         f.ie = w[LVL_SHIFT + IE_POS];
         f.cd = w[LVL_SHIFT + CD_POS];
      end else begin
         f.sm = w[SM_POS];
         f.ie = w[IE_POS];
         f.cd = w[CD_POS];
      end
      return f;
   endfunction

   function automatic logic [15:0] place_flags(input flags_t lo, input flags_t hi);
      logic [15:0] w;
      w = '0;
      w[SM_POS] = lo.sm;
      w[IE_POS] = lo.ie;
      w[CD_POS] = lo.cd;
      w[LVL_SHIFT + SM_POS] = hi.sm;
      w[LVL_SHIFT + IE_POS] = hi.ie;
      w[LVL_SHIFT + CD_POS] = hi.cd;
      return w;
   endfunction

endpackage

// File: rtl/exr_status.sv
module exr_status
   import exr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_status,
   input  logic   wr_outer,
   input  flags_t wcur,
   input  flags_t wsav,
   input  flags_t wouter,
   input  logic   pop,
   output flags_t cur_q,
   output flags_t sav_q,
   output flags_t outer_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         sav_q   <= '0;
         outer_q <= '0;
      end else if (pop) begin
         cur_q <= sav_q;
         sav_q <= outer_q;
      end else begin
         if (wr_status) begin
            cur_q <= wcur;
            sav_q <= wsav;
         end
         if (wr_outer) begin
            outer_q <= wouter;
         end
      end
   end

   AST_CUR_POP: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> cur_q == $past(sav_q)); // R5
   AST_SAV_POP: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> sav_q == $past(outer_q)); // R6
   AST_OUTER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> $stable(outer_q)); // R6
   AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !wr_status) |=> ($stable(cur_q) && $stable(sav_q))); // R9

endmodule

// File: rtl/exr_addr.sv
module exr_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned ALIGN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ra1,
   input  logic          wr_ra2,
   input  logic [AW-1:0] wdata,
   input  logic          pop,
   output logic [AW-1:0] ra1_q,
   output logic [AW-1:0] ra2_q,
   output logic [AW-1:0] redirect
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ra1_q <= '0;
         ra2_q <= '0;
      end else if (pop) begin
         ra1_q <= ra2_q;
      end else begin
         if (wr_ra1) ra1_q <= wdata;
         if (wr_ra2) ra2_q <= wdata;
      end
   end

   if (ALIGN == 0) begin : g_noalign
      assign redirect = ra1_q;
   end else begin : g_align
      assign redirect = {ra1_q[AW-1:ALIGN], {ALIGN{1'b0}}};
   end

   AST_RA1_POP: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> ra1_q == $past(ra2_q)); // R8
   AST_RA2_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> $stable(ra2_q)); // R8

endmodule

// File: rtl/exr_rdmux.sv
module exr_rdmux
   import exr_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  flags_t           cur,
   input  flags_t           sav,
   input  flags_t           outer,
   input  logic [AW-1:0]    ra1,
   input  logic [AW-1:0]    ra2,
   output logic [DW-1:0]    rdata
);

   logic [DW-1:0] ra1_ext, ra2_ext;

   if (AW == DW) begin : g_full
      assign ra1_ext = ra1;
      assign ra2_ext = ra2;
   end else begin : g_ext
      assign ra1_ext = {{(DW-AW){1'b0}}, ra1};
      assign ra2_ext = {{(DW-AW){1'b0}}, ra2};
   end

   always_comb begin
      rdata = '0;
      if (idx == IDX_W'(IDX_STATUS))
         rdata[15:0] = place_flags(cur, sav);
      else if (idx == IDX_W'(IDX_OUTER))
         rdata[15:0] = place_flags(outer, '0);
      else if (idx == IDX_W'(IDX_RA1))
         rdata = ra1_ext;
      else if (idx == IDX_W'(IDX_RA2))
         rdata = ra2_ext;
   end

endmodule

// File: rtl/exr_unit.sv
module exr_unit
   import exr_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned ALIGN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             creg_we,
   input  logic [IDX_W-1:0] creg_idx,
   input  logic [DW-1:0]    creg_wdata,
   output logic [DW-1:0]    creg_rdata,
   input  logic             ret_strobe,
   output logic             redirect_valid,
   output logic [AW-1:0]    redirect_pc
);

   if (DW < 16) begin : g_chk_dw
      $error("exr_unit: DW must be at least 16");
   end
   if (AW > DW || AW <= ALIGN) begin : g_chk_aw
      $error("exr_unit: AW must satisfy ALIGN < AW <= DW");
   end
   if (IDX_W < 2) begin : g_chk_idx
      $error("exr_unit: IDX_W must be at least 2");
   end

   logic   acc;
   logic   wr_status, wr_outer, wr_ra1, wr_ra2;
   flags_t cur_q, sav_q, outer_q;
   logic [AW-1:0] ra1_q, ra2_q;

   assign acc       = creg_we && !ret_strobe;
   assign wr_status = acc && (creg_idx == IDX_W'(IDX_STATUS));
   assign wr_outer  = acc && (creg_idx == IDX_W'(IDX_OUTER));
   assign wr_ra1    = acc && (creg_idx == IDX_W'(IDX_RA1));
   assign wr_ra2    = acc && (creg_idx == IDX_W'(IDX_RA2));

   exr_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_status (wr_status),
      .wr_outer  (wr_outer),
      .wcur      (pick_flags(creg_wdata[15:0], 1'b0)),
      .wsav      (pick_flags(creg_wdata[15:0], 1'b1)),
      .wouter    (pick_flags(creg_wdata[15:0], 1'b0)),
      .pop       (ret_strobe),
      .cur_q     (cur_q),
      .sav_q     (sav_q),
      .outer_q   (outer_q)
   );

   exr_addr #(.AW(AW), .ALIGN(ALIGN)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ra1   (wr_ra1),
      .wr_ra2   (wr_ra2),
      .wdata    (creg_wdata[AW-1:0]),
      .pop      (ret_strobe),
      .ra1_q    (ra1_q),
      .ra2_q    (ra2_q),
      .redirect (redirect_pc)
   );

   exr_rdmux #(.DW(DW), .AW(AW), .IDX_W(IDX_W)) u_rd (
      .idx   (creg_idx),
      .cur   (cur_q),
      .sav   (sav_q),
      .outer (outer_q),
      .ra1   (ra1_q),
      .ra2   (ra2_q),
      .rdata (creg_rdata)
   );

   assign redirect_valid = ret_strobe;

   AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (redirect_pc[AW-1:ALIGN] == ra1_q[AW-1:ALIGN])); // R7
   AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_strobe && creg_we && creg_idx == IDX_W'(IDX_OUTER)) |=> $stable(outer_q)); // R9

endmodule

// File: tb/exr_unit_test.sv
`timescale 1ns/1ps
module exr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        creg_we = 1'b0;
   logic [3:0]  creg_idx = '0;
   logic [31:0] creg_wdata = '0;
   logic [31:0] creg_rdata;
   logic        ret_strobe = 1'b0;
   logic        redirect_valid;
   logic [31:0] redirect_pc;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   exr_unit uut (
      .clk(clk), .rst_n(rst_n), .creg_we(creg_we), .creg_idx(creg_idx),
      .creg_wdata(creg_wdata), .creg_rdata(creg_rdata), .ret_strobe(ret_strobe),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   // flags {sm,ie,cd} placed at base+7, base+6, base+0
   function automatic logic [31:0] fw(input logic [2:0] f, input int base);
      return (32'(f[2]) << (base + 7)) | (32'(f[1]) << (base + 6)) | (32'(f[0]) << base);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      creg_we = 1'b1; creg_idx = idx; creg_wdata = d;
      @(negedge clk);
      creg_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [3:0] idx, input logic [31:0] exp);
      creg_idx = idx;
      #1;
      chk(req, creg_rdata, exp);
   endtask

   task automatic do_ret(input logic [31:0] exp_pc);
      @(negedge clk);
      ret_strobe = 1'b1;
      #1;
      chk("R7 valid", {31'd0, redirect_valid}, 32'd1);
      chk("R7 pc", redirect_pc, exp_pc);
      @(negedge clk);
      ret_strobe = 1'b0;
      #1;
      chk("R7 valid low", {31'd0, redirect_valid}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < 16; i++) rd("R1 reset", 4'(i), 32'd0);

      // R4 unused indices: write all ones, nothing changes
      for (int i = 4; i < 16; i++) wr(4'(i), 32'hFFFF_FFFF);
      for (int i = 0; i < 16; i++) rd("R4 unused ignored", 4'(i), 32'd0);

      // near-exhaustive sweep
      for (int s = 0; s < 64; s++) begin
         for (int b = 0; b < 8; b++) begin
            logic [2:0]  cur, sav, outer;
            logic [31:0] a1, a2;
            cur = 3'(s); sav = 3'(s >> 3); outer = 3'(b);
            a1 = 32'h1000_0000 + 32'(s * 256) + 32'(b * 4) + 32'(s % 4);
            a2 = ~a1;
            wr(4'd0, fw(cur, 0) | fw(sav, 8) | 32'hA5A5_3E3E);
            wr(4'd1, fw(outer, 0) | 32'hFFFF_FF3E);
            wr(4'd2, a1);
            wr(4'd3, a2);
            rd("R2 status", 4'd0, fw(cur, 0) | fw(sav, 8));
            rd("R3 outer", 4'd1, fw(outer, 0));
            rd("R10 ra1", 4'd2, a1);
            do_ret(a1 & 32'hFFFF_FFFC);
            rd("R5 R6 status pop", 4'd0, fw(sav, 0) | fw(outer, 8));
            rd("R6 outer kept", 4'd1, fw(outer, 0));
            rd("R8 ra1 pop", 4'd2, a2);
            rd("R8 ra2 kept", 4'd3, a2);
         end
      end

      // R9: write and return in same cycle
      wr(4'd0, 32'h0000_C100);
      wr(4'd1, 32'h0000_0041);
      wr(4'd2, 32'h0000_1236);
      wr(4'd3, 32'h0000_4000);
      @(negedge clk);
      ret_strobe = 1'b1; creg_we = 1'b1; creg_idx = 4'd0; creg_wdata = 32'h0000_FFFF;
      #1;
      chk("R9 redirect", redirect_pc, 32'h0000_1234);
      @(negedge clk);
      ret_strobe = 1'b0; creg_we = 1'b0;
      rd("R9 status popped not written", 4'd0, 32'h0000_41C1);
      @(negedge clk);
      ret_strobe = 1'b1; creg_we = 1'b1; creg_idx = 4'd1; creg_wdata = 32'h0000_00FF;
      @(negedge clk);
      ret_strobe = 1'b0; creg_we = 1'b0;
      rd("R9 outer write dropped", 4'd1, 32'h0000_0041);
      rd("R9 status second pop", 4'd0, 32'h0000_4141);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule